// File: doc/BRIEF.md
# Background ECC Scrub Engine

The block walks a single-port memory array one word after another, looking at each stored codeword with a single-error-correct, double-error-detect code. A word with one flipped bit is rewritten in corrected form. A word with two flipped bits is left as it is and reported. Host traffic always wins the memory port, and the scrubber only uses cycles the host leaves idle. Host reads come back already corrected, and host writes are encoded on their way in.

Before power is cut, a shutdown handshake lets the host park the engine. The engine first finishes the word it is working on. It then writes its next scan address into an external retained register, which survives power loss, and only after that raises the acknowledge. On every reset the engine restarts from the retained address if one was ever saved, and from address 0 otherwise. Because of this, scrub coverage adds up across any number of controlled power cycles.

Top module: `ecc_scrub`

## Requirements
- R1: While and right after reset, `sd_ack_o`, `ret_we_o`, `pass_o` and `err_o` are 0.
- R2: The first scrub read after reset targets `ret_pos_i` when `ret_valid_i` is 1, and address 0 otherwise. A reset with no save in between therefore resumes at the last saved position, not at the position reached before the power loss.
- R3: During a cycle with `fg_req_i` high, the memory port carries the host access (same address, write enable and encoded data), and the scrubber issues nothing. Host read data appears on `fg_rdata_o` one cycle later, with any single-bit error corrected.
- R4: A word holding a single-bit error is rewritten with the corrected codeword before the scan completes its following pass.
- R5: A word with a double-bit error is never rewritten by the scrubber. `err_o` rises and stays high until reset. `err_addr_o` holds the address of the first such word and does not change afterwards.
- R6: Scan addresses rise by one and wrap from DEPTH-1 to 0. `pass_o` is a one-cycle pulse, raised in the cycle after the check of word DEPTH-1 completes.
- R7: Once `sd_req_i` is seen, the engine finishes any read-check-rewrite in progress. It then pulses `ret_we_o` once, with `ret_pos_o` set to the next unscanned address, and raises `sd_ack_o` in the following cycle. `sd_ack_o` stays high with no scrub traffic until `sd_req_i` drops, and scanning then resumes at the saved address.
- R8: A host write to the word whose rewrite is pending cancels that rewrite, so the host data survives.
- R9: A flip of any single codeword bit, including the check bits and the overall parity bit, is corrected, both on host reads and by the scrubber.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fg_req_i | input | 1 | Host access request (always granted) |
| fg_we_i | input | 1 | Host write enable |
| fg_addr_i | input | ADDR_W | Host word address |
| fg_wdata_i | input | DATA_W | Host write data |
| fg_rdata_o | output | DATA_W | Corrected host read data, one cycle after the read |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | CW_W | Codeword to store |
| mem_rdata_i | input | CW_W | Codeword read, one cycle after the read strobe |
| sd_req_i | input | 1 | Shutdown permission request |
| sd_ack_o | output | 1 | Shutdown permitted |
| ret_valid_i | input | 1 | Retained register has ever been written |
| ret_pos_i | input | ADDR_W | Retained scan position |
| ret_we_o | output | 1 | Write strobe for the retained register |
| ret_pos_o | output | ADDR_W | Position to retain |
| pass_o | output | 1 | One-cycle pulse at scan wrap |
| err_o | output | 1 | Sticky uncorrectable-error flag |
| err_addr_o | output | ADDR_W | Address of the first uncorrectable word |

## Verification
The bench builds the engine with DATA_W=8 and DEPTH=8. This gives a 13-bit codeword, so every one of its bit positions can be flipped in turn, and each flip can be seen repaired within two short passes. The small depth makes wraps frequent, so the wrap address and the pass pulse are checked many times. The bench holds a retained-register model that no reset clears. Against it, the bench checks resume after a controlled shutdown, a shutdown that lands during a pending rewrite, a shutdown followed by power loss, and a power loss with no save in between. A host write is timed to land on the word whose rewrite is pending, which exercises the cancel path.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_RD,
    ST_CHK,
    ST_WB,
    ST_ACK
  } scrub_state_e;

  // Hamming check bits needed for dw data bits
  function automatic int par_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc #(
  parameter int DATA_W = 8,
  localparam int P     = ecc_scrub_pkg::par_bits(DATA_W),
  localparam int N     = DATA_W + P,
  localparam int CW_W  = N + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);

  always_comb begin
    logic [CW_W-1:0] cw;
    logic            par;
    int              d;
    cw = '0;
    d  = 0;
    for (int i = 1; i <= N; i++) begin
      if ((i & (i - 1)) != 0) begin
        cw[i] = data_i[d];
        d++;
      end
    end
    for (int k = 0; k < P; k++) begin
      par = 1'b0;
      for (int i = 1; i <= N; i++) begin
        if (((i >> k) & 1) != 0) par = par ^ cw[i];
      end
      cw[1 << k] = par;
    end
    cw[0] = ^cw[N:1];
    cw_o  = cw;
  end

endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec #(
  parameter int DATA_W = 8,
  localparam int P     = ecc_scrub_pkg::par_bits(DATA_W),
  localparam int N     = DATA_W + P,
  localparam int CW_W  = N + 1
) (
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CW_W-1:0]   cw_fix_o,
  output logic              sgl_o,
  output logic              dbl_o
);

  logic [P-1:0]    syn;
  logic            ovl;
  logic [CW_W-1:0] fix;

  always_comb begin
    syn = '0;
    for (int i = 1; i <= N; i++) begin
      if (cw_i[i]) syn = syn ^ P'(i);
    end
    ovl   = ^cw_i;
    fix   = cw_i;
    sgl_o = 1'b0;
    dbl_o = 1'b0;
    if (ovl) begin
      if (syn == '0) begin
        fix[0] = ~fix[0];
        sgl_o  = 1'b1;
      end else if (int'(syn) <= N) begin
        fix[syn] = ~fix[syn];
        sgl_o    = 1'b1;
      end else begin
        dbl_o = 1'b1;  // syndrome outside codeword: multi-bit
      end
    end else if (syn != '0) begin
      dbl_o = 1'b1;
    end
    cw_fix_o = fix;
  end

  always_comb begin
    int d;
    d      = 0;
    data_o = '0;
    for (int i = 1; i <= N; i++) begin
      if ((i & (i - 1)) != 0) begin
        data_o[d] = fix[i];
        d++;
      end
    end
  end

endmodule

// File: rtl/ecc_scrub_fsm.sv
module ecc_scrub_fsm
  import ecc_scrub_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CW_W   = 13,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fg_req_i,
  input  logic              fg_we_i,
  input  logic [ADDR_W-1:0] fg_addr_i,
  input  logic              sd_req_i,
  output logic              sd_ack_o,
  input  logic              ret_valid_i,
  input  logic [ADDR_W-1:0] ret_pos_i,
  output logic              ret_we_o,
  output logic [ADDR_W-1:0] ret_pos_o,
  output logic              scr_req_o,
  output logic              scr_we_o,
  output logic [ADDR_W-1:0] scr_addr_o,
  output logic [CW_W-1:0]   scr_wdata_o,
  input  logic [CW_W-1:0]   rd_fix_i,
  input  logic              rd_sgl_i,
  input  logic              rd_dbl_i,
  output logic              pass_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] err_addr_o
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  scrub_state_e      state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, start_pos;
  logic [CW_W-1:0]   fix_q;
  logic              pass_q, err_q;
  logic [ADDR_W-1:0] err_addr_q;
  logic              gnt, fg_hit, adv, save, dbl_evt;

  assign start_pos = (ret_valid_i && (int'(ret_pos_i) < DEPTH)) ? ret_pos_i : '0;

  assign scr_req_o   = ((state_q == ST_RD) && !sd_req_i) || (state_q == ST_WB);
  assign scr_we_o    = (state_q == ST_WB);
  assign scr_addr_o  = ptr_q;
  assign scr_wdata_o = fix_q;
  assign gnt         = scr_req_o && !fg_req_i;
  // host write to the word in flight makes our copy stale
  assign fg_hit      = fg_req_i && fg_we_i && (fg_addr_i == ptr_q);
  assign dbl_evt     = (state_q == ST_CHK) && rd_dbl_i && !fg_hit;

  always_comb begin
    state_d = state_q;
    adv     = 1'b0;
    save    = 1'b0;
    unique case (state_q)
      ST_INIT: state_d = ST_RD;
      ST_RD: begin
        if (sd_req_i) begin
          save    = 1'b1;
          state_d = ST_ACK;
        end else if (gnt) begin
          state_d = ST_CHK;
        end
      end
      ST_CHK: begin
        if (rd_sgl_i && !fg_hit) begin
          state_d = ST_WB;
        end else begin
          adv     = 1'b1;
          state_d = ST_RD;
        end
      end
      ST_WB: begin
        if (fg_hit || gnt) begin
          adv     = 1'b1;
          state_d = ST_RD;
        end
      end
      ST_ACK: if (!sd_req_i) state_d = ST_RD;
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_INIT;
      ptr_q      <= '0;
      fix_q      <= '0;
      pass_q     <= 1'b0;
      err_q      <= 1'b0;
      err_addr_q <= '0;
    end else begin
      state_q <= state_d;
      pass_q  <= adv && (ptr_q == LAST);
      if (state_q == ST_INIT) ptr_q <= start_pos;
      else if (adv)           ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      if (state_q == ST_CHK)  fix_q <= rd_fix_i;
      if (dbl_evt && !err_q) begin
        err_q      <= 1'b1;
        err_addr_q <= ptr_q;
      end
    end
  end

  assign sd_ack_o   = (state_q == ST_ACK);
  assign ret_we_o   = save;
  assign ret_pos_o  = ptr_q;
  assign pass_o     = pass_q;
  assign err_o      = err_q;
  assign err_addr_o = err_addr_q;

  a_r7_ack_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_ack_o |-> !scr_req_o);
  a_r7_save_then_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_ack_o) |-> $past(ret_we_o));
  a_r7_save_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_we_o |-> sd_req_i);
  a_r6_pass_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |=> !pass_o);
  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && $stable(err_addr_o));
  a_r3_yield: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD && fg_req_i && !sd_req_i) |=> state_q == ST_RD);
  a_r4_wb_needs_sgl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB && $past(state_q) != ST_WB) |-> $past(rd_sgl_i));

endmodule

// File: rtl/ecc_scrub.sv
module ecc_scrub #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CW_W   = DATA_W + ecc_scrub_pkg::par_bits(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fg_req_i,
  input  logic              fg_we_i,
  input  logic [ADDR_W-1:0] fg_addr_i,
  input  logic [DATA_W-1:0] fg_wdata_i,
  output logic [DATA_W-1:0] fg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [CW_W-1:0]   mem_wdata_o,
  input  logic [CW_W-1:0]   mem_rdata_i,
  input  logic              sd_req_i,
  output logic              sd_ack_o,
  input  logic              ret_valid_i,
  input  logic [ADDR_W-1:0] ret_pos_i,
  output logic              ret_we_o,
  output logic [ADDR_W-1:0] ret_pos_o,
  output logic              pass_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] err_addr_o
);

  logic [CW_W-1:0]   fg_cw, rd_fix, scr_wdata;
  logic              rd_sgl, rd_dbl, scr_req, scr_we;
  logic [ADDR_W-1:0] scr_addr;

  ecc_secded_enc #(.DATA_W(DATA_W)) u_enc (
    .data_i (fg_wdata_i),
    .cw_o   (fg_cw)
  );

  ecc_secded_dec #(.DATA_W(DATA_W)) u_dec (
    .cw_i     (mem_rdata_i),
    .data_o   (fg_rdata_o),
    .cw_fix_o (rd_fix),
    .sgl_o    (rd_sgl),
    .dbl_o    (rd_dbl)
  );

  ecc_scrub_fsm #(.DEPTH(DEPTH), .CW_W(CW_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fg_req_i    (fg_req_i),
    .fg_we_i     (fg_we_i),
    .fg_addr_i   (fg_addr_i),
    .sd_req_i    (sd_req_i),
    .sd_ack_o    (sd_ack_o),
    .ret_valid_i (ret_valid_i),
    .ret_pos_i   (ret_pos_i),
    .ret_we_o    (ret_we_o),
    .ret_pos_o   (ret_pos_o),
    .scr_req_o   (scr_req),
    .scr_we_o    (scr_we),
    .scr_addr_o  (scr_addr),
    .scr_wdata_o (scr_wdata),
    .rd_fix_i    (rd_fix),
    .rd_sgl_i    (rd_sgl),
    .rd_dbl_i    (rd_dbl),
    .pass_o      (pass_o),
    .err_o       (err_o),
    .err_addr_o  (err_addr_o)
  );

  // host owns the port whenever it asks
  always_comb begin
    if (fg_req_i) begin
      mem_req_o   = 1'b1;
      mem_we_o    = fg_we_i;
      mem_addr_o  = fg_addr_i;
      mem_wdata_o = fg_cw;
    end else begin
      mem_req_o   = scr_req;
      mem_we_o    = scr_we;
      mem_addr_o  = scr_addr;
      mem_wdata_o = scr_wdata;
    end
  end

  a_r3_scrub_write_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !fg_req_i) |-> (^mem_wdata_o) == 1'b0);

endmodule

// File: tb/ecc_scrub_bench.sv
module ecc_scrub_bench;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CW_W   = 13;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fg_req_i = 1'b0, fg_we_i = 1'b0;
  logic [ADDR_W-1:0] fg_addr_i = '0;
  logic [DATA_W-1:0] fg_wdata_i = '0;
  logic [DATA_W-1:0] fg_rdata_o;
  logic mem_req_o, mem_we_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [CW_W-1:0] mem_wdata_o;
  logic [CW_W-1:0] mem_rdata_i = '0;
  logic sd_req_i = 1'b0, sd_ack_o;
  logic ret_we_o;
  logic [ADDR_W-1:0] ret_pos_o;
  logic pass_o, err_o;
  logic [ADDR_W-1:0] err_addr_o;

  logic [ADDR_W-1:0] ret_reg = '0;
  logic ret_vld = 1'b0;
  int ret_cnt = 0;

  logic [CW_W-1:0] mem [DEPTH] = '{default: '0};
  logic inj_en = 1'b0;
  logic [ADDR_W-1:0] inj_addr = '0;
  logic [CW_W-1:0] inj_mask = '0;

  int checks = 0, errors = 0;
  int last_rd = -1, exp_next = 0, pass_cnt = 0;
  logic prev_pass = 1'b0;
  logic [DATA_W-1:0] data_m [DEPTH];
  logic [CW_W-1:0] clean [DEPTH];

  always #(CLK_P/2) clk_i = ~clk_i;

  ecc_scrub #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ecc_scrub (
    .clk_i, .rst_ni, .fg_req_i, .fg_we_i, .fg_addr_i, .fg_wdata_i, .fg_rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .sd_req_i, .sd_ack_o, .ret_valid_i(ret_vld), .ret_pos_i(ret_reg),
    .ret_we_o, .ret_pos_o, .pass_o, .err_o, .err_addr_o
  );

  // memory and retained-register models (retained one ignores reset)
  always @(posedge clk_i) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else mem_rdata_i <= mem[mem_addr_o];
    end
    if (inj_en) mem[inj_addr] <= ((mem_req_o && mem_we_o && mem_addr_o == inj_addr)
                                  ? mem_wdata_o : mem[inj_addr]) ^ inj_mask;
    if (ret_we_o) begin
      ret_reg <= ret_pos_o;
      ret_vld <= 1'b1;
      ret_cnt <= ret_cnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor, sampled 1 time unit after the falling edge
  always begin
    @(negedge clk_i);
    #1;
    if (!rst_ni) begin
      last_rd = -1;
      exp_next = ret_vld ? int'(ret_reg) : 0;
      prev_pass = 1'b0;
    end else begin
      if (fg_req_i) begin
        chk("R3", "host owns port", {mem_req_o, mem_we_o, mem_addr_o},
            {1'b1, fg_we_i, fg_addr_i});
      end
      if (sd_ack_o) chk("R7", "no scrub traffic during ack", mem_req_o && !fg_req_i, 0);
      if (pass_o) begin
        chk("R6", "pass pulse one cycle", prev_pass, 0);
        chk("R6", "pass after last word", last_rd, DEPTH - 1);
        exp_next = 0;
        pass_cnt++;
      end
      prev_pass = pass_o;
      if (mem_req_o && !mem_we_o && !fg_req_i) begin
        if (exp_next >= 0) chk("R2/R6/R7", "scan address", mem_addr_o, exp_next);
        else if (last_rd >= 0) chk("R6", "scan step", mem_addr_o, (last_rd + 1) % DEPTH);
        exp_next = -1;
        last_rd = int'(mem_addr_o);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic fg_write(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk_i);
    fg_req_i = 1'b1; fg_we_i = 1'b1; fg_addr_i = ADDR_W'(a); fg_wdata_i = d;
    @(negedge clk_i);
    fg_req_i = 1'b0; fg_we_i = 1'b0;
  endtask

  task automatic fg_read(input int a, output logic [DATA_W-1:0] d);
    @(negedge clk_i);
    fg_req_i = 1'b1; fg_we_i = 1'b0; fg_addr_i = ADDR_W'(a);
    @(negedge clk_i);
    fg_req_i = 1'b0;
    #1 d = fg_rdata_o;
  endtask

  task automatic inject(input int a, input logic [CW_W-1:0] m);
    @(negedge clk_i);
    inj_en = 1'b1; inj_addr = ADDR_W'(a); inj_mask = m;
    @(negedge clk_i);
    inj_en = 1'b0;
  endtask

  task automatic wait_passes(input int n);
    int c0;
    c0 = pass_cnt;
    while (pass_cnt < c0 + n) @(negedge clk_i);
  endtask

  task automatic wait_scrub_read(input int a);
    do begin
      @(negedge clk_i);
      #1;
    end while (!(mem_req_o && !mem_we_o && !fg_req_i && int'(mem_addr_o) == a));
  endtask

  task automatic wait_ack();
    do begin
      @(negedge clk_i);
      #1;
    end while (!sd_ack_o);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] rd;
    int c0, sv;
    // R1: reset state
    repeat (2) @(negedge clk_i);
    #1;
    chk("R1", "ack in reset", sd_ack_o, 0);
    chk("R1", "ret_we in reset", ret_we_o, 0);
    chk("R1", "err in reset", err_o, 0);
    rst_ni = 1'b1;
    #1;
    chk("R1", "pass after reset", pass_o, 0);
    chk("R1", "err after reset", err_o, 0);
    chk("R1", "ack after reset", sd_ack_o, 0);

    // fill array; R2 first-read-at-0 checked by monitor
    for (int a = 0; a < DEPTH; a++) begin
      data_m[a] = DATA_W'(a * 37 + 5);
      fg_write(a, data_m[a]);
      clean[a] = mem[a];
    end
    for (int a = 0; a < DEPTH; a++) begin
      fg_read(a, rd);
      chk("R3", "host read back", rd, data_m[a]);
    end

    // R9/R4: every single bit position
    for (int b = 0; b < CW_W; b++) begin
      inject(b % DEPTH, CW_W'(1) << b);
      fg_read(b % DEPTH, rd);
      chk("R9", "corrected host read", rd, data_m[b % DEPTH]);
      wait_passes(2);
      chk("R4", "scrubbed word restored", mem[b % DEPTH], clean[b % DEPTH]);
    end
    chk("R5", "no error after singles", err_o, 0);

    // R5: double errors left unchanged, first address held
    inject(5, 13'h006);
    wait_passes(2);
    chk("R5", "double word untouched", mem[5], clean[5] ^ 13'h006);
    chk("R5", "err flag", err_o, 1);
    chk("R5", "err address", err_addr_o, 5);
    inject(5, 13'h006);
    inject(2, 13'h081);
    wait_passes(2);
    chk("R5", "second double untouched", mem[2], clean[2] ^ 13'h081);
    chk("R5", "err stays", err_o, 1);
    chk("R5", "first address kept", err_addr_o, 5);
    inject(2, 13'h081);

    // R8: host write lands on word with pending rewrite
    inject(3, 13'h010);
    wait_scrub_read(3);
    data_m[3] = 8'hC3;
    fg_write(3, data_m[3]);
    wait_passes(1);
    fg_read(3, rd);
    chk("R8", "host data survives", rd, data_m[3]);
    clean[3] = mem[3];

    // R7: plain shutdown, then release
    c0 = ret_cnt;
    @(negedge clk_i);
    sd_req_i = 1'b1;
    wait_ack();
    chk("R7", "one save", ret_cnt - c0, 1);
    chk("R7", "saved next address", ret_reg, (last_rd + 1) % DEPTH);
    sv = int'(ret_reg);
    repeat (5) @(negedge clk_i);
    #1 chk("R7", "ack held", sd_ack_o, 1);
    sd_req_i = 1'b0;
    exp_next = sv;
    wait_passes(1);

    // R7: shutdown during pending rewrite
    inject(6, 13'h020);
    wait_scrub_read(6);
    @(negedge clk_i);
    sd_req_i = 1'b1;
    wait_ack();
    chk("R7", "rewrite finished before ack", mem[6], clean[6]);
    chk("R7", "saved after rewritten word", ret_reg, 7);

    // R2: power loss after controlled save
    sd_req_i = 1'b0;
    do_reset();
    #1 chk("R1", "ack cleared by reset", sd_ack_o, 0);
    wait_passes(1);
    chk("R2", "resumed at saved pos", ret_reg, 7);

    // R2: uncontrolled loss with no new save
    repeat (11) @(negedge clk_i);
    c0 = ret_cnt;
    do_reset();
    wait_passes(2);
    chk("R2", "no save on power loss", ret_cnt - c0, 0);
    for (int a = 0; a < DEPTH; a++) begin
      fg_read(a, rd);
      chk("R9", "final contents", rd, data_m[a]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule